// File: doc/BRIEF.md
# Peripheral Request-to-Channel Router

The router sits between a large set of peripheral DMA request lines and a smaller bank of DMA channels. Software assigns each request line to a channel by writing a small map entry. The entry holds an enable bit and a channel number. Each channel raises its request output whenever any enabled request line assigned to it is active. A fixed four-level priority arbiter picks one requesting channel at a time to serve. The grant stays on that channel until the transfer engine signals the end of the burst.

The map entries sit in two address windows, 64 entries to a window. Request n below 64 is at byte offset 0x100 + 4*n. Request n of 64 or above is at 0x1100 + 4*(n-64). The block also gathers the per-channel interrupt pending flags from the transfer engine into one summary word. Software reads that word at offset 0x0F0 to find which channels need service behind a single shared interrupt line.

Top module: `dreq_router`

## Requirements
- R1: After reset every map entry is disabled and reads as zero, and chan_req, chan_gnt, irq_summary and irq_out are all zero.
- R2: A write stores wdata bit 7 as the enable bit and wdata bits 4:0 as the channel number. A read returns them in the same bit positions, with bits 6:5 and 31:8 reading zero. The read data appears on reg_rdata in the cycle after reg_rd is sampled.
- R3: Request n < 64 decodes at 0x100 + 4*n and request n >= 64 at 0x1100 + 4*(n-64). A write to any other address, including an unaligned one, changes no map entry.
- R4: chan_req[c] rises one clock after an active request line whose entry is enabled and names channel c.
- R5: A request line whose entry has the enable bit clear drives no channel, even if the entry names a channel. Writing zero to an entry removes its routing.
- R6: Several request lines mapped to the same channel are ORed: the channel stays requested while any of them is active.
- R7: The priority level of channel c is (c mod 16)/4, and level 0 is the highest. A requesting channel at a higher level wins over any lower level, in either half of the channel set. For example, channel 17 wins over channel 4.
- R8: Within one level the lowest channel index wins. For example, channel 3 wins over channel 16 and channel 17.
- R9: chan_gnt is one-hot or zero. A grant is issued one clock after chan_req shows a requester while no grant is held. It is then held unchanged until burst_done is sampled high, falls to zero on the next clock, and a new arbitration follows one clock later.
- R10: irq_summary mirrors chan_irq_src with one clock of delay. A read at offset 0x0F0 returns it.
- R11: irq_out is high exactly when some irq_summary bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 8 | Write data (map entry byte) |
| reg_rdata | output | 32 | Registered read data |
| periph_req | input | 128 | Peripheral request lines |
| burst_done | input | 1 | End of the burst for the granted channel |
| chan_irq_src | input | 32 | Per-channel interrupt pending flags from the engine |
| chan_req | output | 32 | Per-channel request after routing |
| chan_gnt | output | 32 | One-hot grant to the winning channel |
| irq_summary | output | 32 | Registered summary of pending channel interrupts |
| irq_out | output | 1 | Shared interrupt, OR of the summary |

## Verification
The bench checks that the top of the second window (0x11FC, request 127) and a high-window entry (request 100) land on the correct request lines. A decoder that dropped address bit 12 would alias those writes onto low requests. Writes to addresses outside both windows and to unaligned addresses are checked to leave the map unchanged, since a loose decoder would corrupt an entry. The bench checks that an entry with the enable bit clear but a channel number set routes nothing, which catches gating on the channel field alone. The priority scenario posts requests on channels 3, 4, 12, 16, 17 and 31 together and retires them one burst at a time. The grant must follow 3, 16, 17, 4, 12, 31, so an arbiter that ranked by raw index, or that did not interleave the two halves, would leave that order.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  localparam int          REQ_IDX_W = 7;
  localparam int          VLD_BIT   = 7;
  localparam logic [15:0] SUM_ADDR  = 16'h00F0;

  typedef struct packed {
    logic                 hit;
    logic [REQ_IDX_W-1:0] idx;
  } map_sel_t;

  // Two windows of 64 word-aligned entries: 0x01xx and 0x11xx.
  function automatic map_sel_t decode_map(input logic [15:0] a);
    map_sel_t s;
    s.hit = (a[15:13] == 3'b000) && (a[11:8] == 4'h1) && (a[1:0] == 2'b00);
    s.idx = {a[12], a[7:2]};
    return s;
  endfunction

  // Four levels; the low and high sixteen channels share level numbers.
  function automatic logic [1:0] prio_level(input int unsigned c);
    return 2'((c % 16) / 4);
  endfunction

endpackage

// File: rtl/dreq_regfile.sv
module dreq_regfile #(
  parameter int NUM_REQ = 128,
  parameter int NUM_CH  = 32,
  parameter int CH_W    = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [15:0]        addr,
  input  logic [7:0]         wdata,
  input  logic [NUM_CH-1:0]  irq_sum,
  output logic [NUM_REQ-1:0] map_vld,
  output logic [CH_W-1:0]    map_ch [NUM_REQ],
  output logic [31:0]        rdata,
  output logic               any_vld
);
  import dreq_pkg::*;

  localparam int PAD_W = dreq_pkg::VLD_BIT - CH_W;

  map_sel_t sel;
  logic     sel_ok;
  logic     unused_wdata;

  assign sel          = decode_map(addr);
  assign sel_ok       = sel.hit && (int'(sel.idx) < NUM_REQ);
  assign any_vld      = |map_vld;
  assign unused_wdata = ^wdata[VLD_BIT-1:CH_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_vld <= '0;
      for (int r = 0; r < NUM_REQ; r++) map_ch[r] <= '0;
    end else if (wr && sel_ok) begin
      map_vld[sel.idx] <= wdata[VLD_BIT];
      map_ch[sel.idx]  <= wdata[CH_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      if (addr == SUM_ADDR)
        rdata <= 32'(irq_sum);
      else if (sel_ok)
        rdata <= 32'({map_vld[sel.idx], PAD_W'(0), map_ch[sel.idx]});
      else
        rdata <= '0;
    end
  end

endmodule

// File: rtl/dreq_fanin.sv
module dreq_fanin #(
  parameter int NUM_REQ = 128,
  parameter int NUM_CH  = 32,
  parameter int CH_W    = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] periph_req,
  input  logic [NUM_REQ-1:0] map_vld,
  input  logic [CH_W-1:0]    map_ch [NUM_REQ],
  output logic [NUM_CH-1:0]  chan_req
);

  logic [NUM_CH-1:0] req_nxt;

  always_comb begin
    req_nxt = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (periph_req[r] && map_vld[r] && (int'(map_ch[r]) < NUM_CH))
        req_nxt[map_ch[r]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chan_req <= '0;
    else        chan_req <= req_nxt;
  end

endmodule

// File: rtl/dreq_prio_arb.sv
module dreq_prio_arb #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_req,
  input  logic              burst_done,
  output logic [NUM_CH-1:0] chan_gnt
);
  import dreq_pkg::*;

  localparam int NUM_LVL = 4;

  logic [NUM_CH-1:0] lvl_req [NUM_LVL];
  logic [NUM_CH-1:0] pick;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign lvl_req[l][c] = chan_req[c] && (prio_level(c) == 2'(l));
    end
  end

  // Later assignments override earlier ones: level 0, lowest index wins.
  always_comb begin
    pick = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      for (int c = NUM_CH - 1; c >= 0; c--) begin
        if (lvl_req[l][c]) begin
          pick    = '0;
          pick[c] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 chan_gnt <= '0;
    else if (chan_gnt == '0)    chan_gnt <= pick;
    else if (burst_done)        chan_gnt <= '0;
  end

endmodule

// File: rtl/dreq_router.sv
module dreq_router #(
  parameter int NUM_REQ = 128,
  parameter int NUM_CH  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [15:0]        reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_REQ-1:0] periph_req,
  input  logic               burst_done,
  input  logic [NUM_CH-1:0]  chan_irq_src,
  output logic [NUM_CH-1:0]  chan_req,
  output logic [NUM_CH-1:0]  chan_gnt,
  output logic [NUM_CH-1:0]  irq_summary,
  output logic               irq_out
);

  localparam int CH_W = $clog2(NUM_CH);

  logic [NUM_REQ-1:0] map_vld;
  logic [CH_W-1:0]    map_ch [NUM_REQ];
  logic               any_map_vld;

  dreq_regfile #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .CH_W(CH_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .irq_sum (irq_summary),
    .map_vld (map_vld),
    .map_ch  (map_ch),
    .rdata   (reg_rdata),
    .any_vld (any_map_vld)
  );

  dreq_fanin #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .CH_W(CH_W)) fanin_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_req (periph_req),
    .map_vld    (map_vld),
    .map_ch     (map_ch),
    .chan_req   (chan_req)
  );

  dreq_prio_arb #(.NUM_CH(NUM_CH)) arb_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_req   (chan_req),
    .burst_done (burst_done),
    .chan_gnt   (chan_gnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_summary <= '0;
    else        irq_summary <= chan_irq_src;
  end

  assign irq_out = |irq_summary;

endmodule

// File: rtl/dreq_router_chk.sv
module dreq_router_chk #(
  parameter int NUM_CH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chan_req,
  input logic [NUM_CH-1:0] chan_gnt,
  input logic              burst_done,
  input logic [NUM_CH-1:0] chan_irq_src,
  input logic [NUM_CH-1:0] irq_summary,
  input logic              any_map_vld
);

  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_gnt));

  // R9
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_gnt != '0) && !burst_done) |=> $stable(chan_gnt));

  // R9
  gnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_gnt != '0) && burst_done) |=> (chan_gnt == '0));

  // R9
  gnt_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_gnt == '0) && (chan_req != '0)) |=> (chan_gnt != '0));

  // R7
  gnt_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_gnt == '0) |=> ((chan_gnt & ~$past(chan_req)) == '0));

  // R5
  no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_map_vld |=> (chan_req == '0));

  // R10
  irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_summary == $past(chan_irq_src)));

endmodule

bind dreq_router dreq_router_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .chan_req     (chan_req),
  .chan_gnt     (chan_gnt),
  .burst_done   (burst_done),
  .chan_irq_src (chan_irq_src),
  .irq_summary  (irq_summary),
  .any_map_vld  (any_map_vld)
);

// File: tb/dreq_router_tb.sv
`timescale 1ns/1ps
module dreq_router_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr, reg_rd;
  logic [15:0]  reg_addr;
  logic [7:0]   reg_wdata;
  logic [31:0]  reg_rdata;
  logic [127:0] periph_req;
  logic         burst_done;
  logic [31:0]  chan_irq_src;
  logic [31:0]  chan_req, chan_gnt, irq_summary;
  logic         irq_out;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dreq_router dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .periph_req(periph_req), .burst_done(burst_done),
    .chan_irq_src(chan_irq_src), .chan_req(chan_req), .chan_gnt(chan_gnt),
    .irq_summary(irq_summary), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] entry_addr(input int n);
    if (n < 64) return 16'(32'h100 + 4 * n);
    return 16'(32'h1100 + 4 * (n - 64));
  endfunction

  // Rank = level*64 + index, smallest wins.
  function automatic int exp_pick(input logic [31:0] m);
    int best = -1;
    int best_rank = 1 << 20;
    for (int c = 0; c < 32; c++) begin
      int rank = ((c % 16) / 4) * 64 + c;
      if (m[c] && rank < best_rank) begin
        best = c;
        best_rank = rank;
      end
    end
    return best;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 chan_req", chan_req, 32'h0);
    check("R1 chan_gnt", chan_gnt, 32'h0);
    check("R1 irq_summary", irq_summary, 32'h0);
    check("R1 irq_out", 32'(irq_out), 32'h0);
    rd(entry_addr(5), d);
    check("R1 map entry", d, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(entry_addr(127), 8'hFF);
    rd(16'h11FC, d);
    check("R2 readback masks bits 6:5", d, 32'h9F);
    wr(entry_addr(3), 8'h05);
    rd(entry_addr(3), d);
    check("R2 disabled entry readback", d, 32'h05);
    wr(16'h0200, 8'h85);
    wr(16'h0101, 8'h86);
    rd(entry_addr(0), d);
    check("R3 stray writes leave entry 0", d, 32'h0);
    periph_req[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R3 stray writes route nothing", chan_req, 32'h0);
    periph_req = '0;
    periph_req[127] = 1'b1;
    @(negedge clk);
    check("R3 request 127 to ch31", chan_req, 32'h8000_0000);
    periph_req = '0;
    wr(entry_addr(127), 8'h00);
  endtask

  task automatic t_route;
    wr(entry_addr(10), 8'h87);
    wr(entry_addr(11), 8'h87);
    wr(entry_addr(100), 8'h99);
    wr(entry_addr(12), 8'h07);
    periph_req[10] = 1'b1;
    @(negedge clk);
    check("R4 request 10 to ch7", chan_req, 32'h0000_0080);
    periph_req[100] = 1'b1;
    @(negedge clk);
    check("R4 high window request 100 to ch25", chan_req, 32'h0200_0080);
    periph_req[11] = 1'b1;
    periph_req[10] = 1'b0;
    @(negedge clk);
    check("R6 OR of two lines on ch7", chan_req, 32'h0200_0080);
    periph_req = '0;
    periph_req[12] = 1'b1;
    @(negedge clk);
    check("R5 disabled entry routes nothing", chan_req, 32'h0);
    wr(entry_addr(10), 8'h00);
    periph_req = '0;
    periph_req[10] = 1'b1;
    @(negedge clk);
    check("R5 cleared entry routes nothing", chan_req, 32'h0);
    periph_req = '0;
  endtask

  task automatic t_prio;
    int chs [6] = '{4, 17, 3, 16, 12, 31};
    logic [31:0] active = '0;
    int exp;
    burst_done = 1'b1;
    repeat (4) @(negedge clk);
    burst_done = 1'b0;
    check("R9 idle grant", chan_gnt, 32'h0);
    for (int i = 0; i < 6; i++) begin
      wr(entry_addr(20 + i), 8'(8'h80 | chs[i]));
      active[chs[i]] = 1'b1;
    end
    for (int i = 0; i < 6; i++) periph_req[20 + i] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    exp = exp_pick(active);
    check("R8 first grant ch3", chan_gnt, 32'h1 << exp);
    repeat (3) @(negedge clk);
    check("R9 grant held", chan_gnt, 32'h1 << exp);
    for (int step = 0; step < 6; step++) begin
      for (int i = 0; i < 6; i++)
        if (chs[i] == exp) periph_req[20 + i] = 1'b0;
      active[exp] = 1'b0;
      burst_done = 1'b1;
      @(negedge clk);
      burst_done = 1'b0;
      check("R9 release after burst", chan_gnt, 32'h0);
      @(negedge clk);
      exp = exp_pick(active);
      if (exp < 0) check("R9 no requester no grant", chan_gnt, 32'h0);
      else         check("R7 next grant by level", chan_gnt, 32'h1 << exp);
    end
  endtask

  task automatic t_irq;
    logic [31:0] d;
    chan_irq_src = 32'h8000_0011;
    @(negedge clk);
    check("R10 summary mirrors", irq_summary, 32'h8000_0011);
    check("R11 irq_out high", 32'(irq_out), 32'h1);
    rd(16'h00F0, d);
    check("R10 summary read", d, 32'h8000_0011);
    chan_irq_src = 32'h0;
    @(negedge clk);
    check("R11 irq_out low", 32'(irq_out), 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    periph_req = '0; burst_done = 1'b0; chan_irq_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_route();
    t_prio();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule